// File: doc/BRIEF.md
# Rectangle Fill Engine

A drawing accelerator that paints a solid, axis-aligned rectangle into a framebuffer, one 32-bit colour value per pixel. Software sets up the block through a small register port. It writes the column and row bounds, the colour, the address of the first pixel and two signed address steps: one per pixel and one per line. It then writes the run bit and polls a status word until the done bit is set.

Once started, the engine walks the rectangle line by line. Each pixel becomes a single write on a pipelined-free, Wishbone-style bus master port. Only one write is outstanding at a time, and the pixel address moves on only after the write is acknowledged. The start address must already point at the first pixel, because the engine never scales the coordinates into an address. A negative pixel step fills each line from right to left. A negative line step walks upward through memory.

Top module: `rect_fill_engine`

## Requirements
- R1: After a synchronous active-high reset, the bus port is quiet (cyc and stb low), the status word reads 0 (busy bit 0 and done bit 1 both clear), and every parameter register reads 0.
- R2: The register indices are 0 control/status, 1 first column, 2 column end, 3 first row, 4 row end, 5 colour, 6 start address, and 7 steps (bits [15:0] the signed pixel step, bits [31:16] the signed line step). Indices 1 to 7 read back the value last written.
- R3: Writing a 1 to bit 0 of index 0 while idle starts the engine. From the next cycle the status word shows busy set and done clear.
- R4: Every pixel write drives cyc, stb and we high and puts the colour on the write data bus. It keeps stb, the address and the data unchanged until ack is seen.
- R5: Within a line, columns run from the first column up to but not including the column end. The first write of the rectangle goes to the start address, and each acknowledged write advances the address by the sign-extended pixel step.
- R6: Lines run from the first row up to but not including the row end. Each new line begins at the previous line's starting address plus the sign-extended line step.
- R7: After a write is acknowledged, cyc and stb are low for at least one cycle before the next write.
- R8: If the column end is not above the first column, or the row end is not above the first row, the engine sets done without issuing any bus write.
- R9: Done stays set after completion until the next start. A run write while busy is ignored and does not change the sequence of writes.
- R10: A complete run issues exactly (column end - first column) x (row end - first row) writes and then sets done.
- R11: Asserting reset during a run stops the writes at once and returns the engine to idle with done cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | 32 | Bus byte address |
| bus_dat_w | output | 32 | Bus write data (colour) |
| bus_ack | input | 1 | Bus acknowledge |

## Verification
Several properties are checked on every cycle:
- the write strobe holds its address and data until acknowledged;
- cyc, stb and we move together;
- a strobe-free cycle follows each acknowledge;
- done is sticky and never coexists with busy;
- a start clears done;
- reset silences the port.

Some properties can only be shown by the directed scenarios, which compare the logged write sequence against addresses computed from the programmed bounds and steps:
- the order and values of the addresses, including backward and upward walks and non-zero first columns;
- the total write count;
- empty rectangles;
- ignored restarts;
- register readback.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    localparam int COORD_W = 16;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int STEP_W  = 16;
    localparam int RIDX_W  = 3;

    localparam logic [RIDX_W-1:0] IDX_CTRL   = 3'd0;
    localparam logic [RIDX_W-1:0] IDX_XFIRST = 3'd1;
    localparam logic [RIDX_W-1:0] IDX_XEND   = 3'd2;
    localparam logic [RIDX_W-1:0] IDX_YFIRST = 3'd3;
    localparam logic [RIDX_W-1:0] IDX_YEND   = 3'd4;
    localparam logic [RIDX_W-1:0] IDX_COLOUR = 3'd5;
    localparam logic [RIDX_W-1:0] IDX_START  = 3'd6;
    localparam logic [RIDX_W-1:0] IDX_STEPS  = 3'd7;

    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_RUN  = 0;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_LINE  = 2'd1,
        WK_WRITE = 2'd2,
        WK_GAP   = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [COORD_W-1:0] x_first;
        logic [COORD_W-1:0] x_end;
        logic [COORD_W-1:0] y_first;
        logic [COORD_W-1:0] y_end;
        logic [DATA_W-1:0]  colour;
        logic [ADDR_W-1:0]  start_addr;
        logic [STEP_W-1:0]  px_step;
        logic [STEP_W-1:0]  ln_step;
    } rect_cfg_t;

    function automatic logic [ADDR_W-1:0] widen_step(input logic [STEP_W-1:0] s);
        return {{(ADDR_W-STEP_W){s[STEP_W-1]}}, s};
    endfunction

endpackage

// File: rtl/rfe_regfile.sv
module rfe_regfile
    import rfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic [DATA_W-1:0] reg_rdata,
    output rect_cfg_t         cfg,
    output logic              start_req
);

    localparam int PAD_W = DATA_W - COORD_W;

    assign start_req = reg_we && (reg_addr == IDX_CTRL) && reg_wdata[BIT_RUN] && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                IDX_XFIRST: cfg.x_first    <= reg_wdata[COORD_W-1:0];
                IDX_XEND:   cfg.x_end      <= reg_wdata[COORD_W-1:0];
                IDX_YFIRST: cfg.y_first    <= reg_wdata[COORD_W-1:0];
                IDX_YEND:   cfg.y_end      <= reg_wdata[COORD_W-1:0];
                IDX_COLOUR: cfg.colour     <= reg_wdata;
                IDX_START:  cfg.start_addr <= reg_wdata[ADDR_W-1:0];
                IDX_STEPS: begin
                    cfg.px_step <= reg_wdata[STEP_W-1:0];
                    cfg.ln_step <= reg_wdata[2*STEP_W-1:STEP_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL: begin
                reg_rdata[BIT_BUSY] = eng_busy;
                reg_rdata[BIT_DONE] = eng_done;
            end
            IDX_XFIRST: reg_rdata = {{PAD_W{1'b0}}, cfg.x_first};
            IDX_XEND:   reg_rdata = {{PAD_W{1'b0}}, cfg.x_end};
            IDX_YFIRST: reg_rdata = {{PAD_W{1'b0}}, cfg.y_first};
            IDX_YEND:   reg_rdata = {{PAD_W{1'b0}}, cfg.y_end};
            IDX_COLOUR: reg_rdata = cfg.colour;
            IDX_START:  reg_rdata = cfg.start_addr;
            IDX_STEPS:  reg_rdata = {cfg.ln_step, cfg.px_step};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
    import rfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rect_cfg_t cfg,
    input  logic      start_req,
    input  logic      bus_ack,
    output logic      eng_busy,
    output logic      eng_done,
    output logic      wr_active,
    output logic      adv_pixel,
    output logic      adv_line
);

    walk_state_e        state;
    logic [COORD_W-1:0] col;
    logic [COORD_W-1:0] row;
    logic               more_cols;
    logic               line_ok;

    assign more_cols = col < cfg.x_end;
    assign line_ok   = (row < cfg.y_end) && (cfg.x_first < cfg.x_end);

    assign eng_busy  = state != WK_IDLE;
    assign wr_active = state == WK_WRITE;
    assign adv_pixel = (state == WK_WRITE) && bus_ack;
    assign adv_line  = (state == WK_GAP) && !more_cols;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WK_IDLE;
            col      <= '0;
            row      <= '0;
            eng_done <= 1'b0;
        end else begin
            case (state)
                WK_IDLE: begin
                    if (start_req) begin
                        col      <= cfg.x_first;
                        row      <= cfg.y_first;
                        eng_done <= 1'b0;
                        state    <= WK_LINE;
                    end
                end
                WK_LINE: begin
                    if (line_ok) begin
                        state <= WK_WRITE;
                    end else begin
                        eng_done <= 1'b1;
                        state    <= WK_IDLE;
                    end
                end
                WK_WRITE: begin
                    if (bus_ack) begin
                        col   <= col + 1'b1;
                        state <= WK_GAP;
                    end
                end
                WK_GAP: begin
                    if (more_cols) begin
                        state <= WK_WRITE;
                    end else begin
                        col   <= cfg.x_first;
                        row   <= row + 1'b1;
                        state <= WK_LINE;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rfe_addr_gen.sv
module rfe_addr_gen
    import rfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [STEP_W-1:0] px_step,
    input  logic [STEP_W-1:0] ln_step,
    input  logic              adv_pixel,
    input  logic              adv_line,
    output logic [ADDR_W-1:0] pix_addr
);

    logic [ADDR_W-1:0] line_addr;
    logic [ADDR_W-1:0] next_line;

    assign next_line = line_addr + widen_step(ln_step);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_addr <= '0;
            pix_addr  <= '0;
        end else if (load) begin
            line_addr <= start_addr;
            pix_addr  <= start_addr;
        end else if (adv_line) begin
            line_addr <= next_line;
            pix_addr  <= next_line;
        end else if (adv_pixel) begin
            pix_addr  <= pix_addr + widen_step(px_step);
        end
    end

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_dat_w,
    input  logic              bus_ack
);

    rect_cfg_t cfg;
    logic      start_req;
    logic      eng_busy;
    logic      eng_done;
    logic      wr_active;
    logic      adv_pixel;
    logic      adv_line;

    rfe_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .reg_rdata (reg_rdata),
        .cfg       (cfg),
        .start_req (start_req)
    );

    rfe_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .start_req (start_req),
        .bus_ack   (bus_ack),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .wr_active (wr_active),
        .adv_pixel (adv_pixel),
        .adv_line  (adv_line)
    );

    rfe_addr_gen u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (start_req),
        .start_addr (cfg.start_addr),
        .px_step    (cfg.px_step),
        .ln_step    (cfg.ln_step),
        .adv_pixel  (adv_pixel),
        .adv_line   (adv_line),
        .pix_addr   (bus_adr)
    );

    assign bus_cyc   = wr_active;
    assign bus_stb   = wr_active;
    assign bus_we    = wr_active;
    assign bus_dat_w = cfg.colour;

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker
    import rfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [RIDX_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_adr,
    input logic [DATA_W-1:0] bus_dat_w,
    input logic              bus_ack,
    input logic              busy,
    input logic              done
);

    logic run_write;
    assign run_write = reg_we && (reg_addr == IDX_CTRL) && reg_wdata[BIT_RUN];

    p_strobe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        bus_stb && !bus_ack |=> bus_stb && $stable(bus_adr) && $stable(bus_dat_w));

    p_write_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_stb == bus_cyc) && (bus_stb == bus_we));

    p_gap_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
        bus_stb && bus_ack |=> !bus_stb && !bus_cyc);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_cyc);

    p_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done && !run_write |=> done);

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        !busy && run_write |=> busy && !done);

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> !bus_cyc && !busy && !done);

endmodule

bind rect_fill_engine rfe_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_adr   (bus_adr),
    .bus_dat_w (bus_dat_w),
    .bus_ack   (bus_ack),
    .busy      (eng_busy),
    .done      (eng_done)
);

// File: tb/rect_fill_engine_tb.sv
`timescale 1ns/1ps
module rect_fill_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        bus_cyc, bus_stb, bus_we, bus_ack;
    logic [31:0] bus_adr, bus_dat_w;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rect_fill_engine dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_ack(bus_ack)
    );

    // slave model: ack after ack_lat wait cycles
    int   ack_lat = 0;
    int   ack_cnt = 0;
    logic ack_r = 1'b0;
    assign bus_ack = ack_r;

    always @(posedge clk) begin
        if (bus_stb && !ack_r) begin
            if (ack_cnt >= ack_lat) begin
                ack_r   <= 1'b1;
                ack_cnt <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else begin
            ack_r   <= 1'b0;
            ack_cnt <= 0;
        end
    end

    // monitor
    logic [31:0] log_adr [0:1023];
    logic [31:0] log_dat [0:1023];
    int   log_n = 0;
    int   gap_viol = 0;
    int   hold_viol = 0;
    int   shape_viol = 0;
    logic prev_acked = 1'b0;
    logic prev_wait = 1'b0;
    logic [31:0] prev_adr = 32'd0;

    always @(posedge clk) begin
        if (!rst) begin
            if (prev_acked && bus_stb) gap_viol++;
            if (prev_wait && (!bus_stb || bus_adr != prev_adr)) hold_viol++;
            if (bus_stb && (!bus_cyc || !bus_we)) shape_viol++;
            if (bus_stb && bus_ack) begin
                if (log_n < 1024) begin
                    log_adr[log_n] = bus_adr;
                    log_dat[log_n] = bus_dat_w;
                end
                log_n++;
            end
        end
        prev_acked = bus_stb && bus_ack;
        prev_wait  = bus_stb && !bus_ack;
        prev_adr   = bus_adr;
    end

    task automatic check(input string req, input string what, input bit ok,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic program_rect(input int x0, input int x1, input int y0, input int y1,
                                input logic [31:0] colour, input logic [31:0] base,
                                input logic signed [15:0] xs, input logic signed [15:0] ys);
        wr(3'd1, 32'(x0)); wr(3'd2, 32'(x1));
        wr(3'd3, 32'(y0)); wr(3'd4, 32'(y1));
        wr(3'd5, colour);  wr(3'd6, base);
        wr(3'd7, {ys, xs});
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd0, s);
            if (s[1]) begin ok = 1; break; end
        end
    endtask

    task automatic verify_log(input string tag, input int x0, input int x1, input int y0,
                              input int y1, input logic [31:0] colour, input logic [31:0] base,
                              input logic signed [15:0] xs, input logic signed [15:0] ys);
        int w = (x1 > x0) ? x1 - x0 : 0;
        int h = (y1 > y0) ? y1 - y0 : 0;
        int bad_a = -1;
        int bad_d = -1;
        logic [31:0] exp_a = 32'd0;
        check({tag, " R10"}, "write count", log_n == w * h, log_n, w * h);
        if (log_n == w * h) begin
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < w; c++) begin
                    int k = r * w + c;
                    logic [31:0] e = base + 32'(r * int'(ys)) + 32'(c * int'(xs));
                    if (bad_a < 0 && log_adr[k] != e) begin bad_a = k; exp_a = e; end
                    if (bad_d < 0 && log_dat[k] != colour) bad_d = k;
                end
            end
            check({tag, " R5 R6"}, "address sequence", bad_a < 0,
                  (bad_a < 0) ? 0 : log_adr[bad_a], (bad_a < 0) ? 0 : exp_a);
            check({tag, " R4"}, "write data", bad_d < 0,
                  (bad_d < 0) ? 0 : log_dat[bad_d], colour);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v);
        check("R1", "status after reset", v == 32'd0, v, 0);
        check("R1", "bus quiet after reset", !bus_cyc && !bus_stb, bus_cyc, 0);
        rd(3'd6, v);
        check("R1", "start addr after reset", v == 32'd0, v, 0);
        rd(3'd7, v);
        check("R1", "steps after reset", v == 32'd0, v, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        program_rect(16'h1234, 16'hbeef, 16'h0042, 16'hffff, 32'hcafe_f00d,
                     32'h8000_0040, -16'sd4, 16'sd5120);
        rd(3'd1, v); check("R2", "first column", v == 32'h1234, v, 32'h1234);
        rd(3'd2, v); check("R2", "column end", v == 32'hbeef, v, 32'hbeef);
        rd(3'd4, v); check("R2", "row end", v == 32'hffff, v, 32'hffff);
        rd(3'd5, v); check("R2", "colour", v == 32'hcafe_f00d, v, 32'hcafe_f00d);
        rd(3'd7, v); check("R2", "steps", v == 32'h1400_fffc, v, 32'h1400_fffc);
    endtask

    task automatic run_rect(input string tag, input int x0, input int x1, input int y0,
                            input int y1, input logic [31:0] colour, input logic [31:0] base,
                            input logic signed [15:0] xs, input logic signed [15:0] ys,
                            input int lat);
        bit ok;
        logic [31:0] s;
        ack_lat = lat;
        program_rect(x0, x1, y0, y1, colour, base, xs, ys);
        log_n = 0; gap_viol = 0; hold_viol = 0; shape_viol = 0;
        wr(3'd0, 32'd1);
        rd(3'd0, s);
        if ((x1 > x0) && (y1 > y0))
            check({tag, " R3"}, "busy set, done clear after start", s[1:0] == 2'b01, s, 1);
        wait_done(ok);
        check({tag, " R10"}, "done reached", ok, ok, 1);
        verify_log(tag, x0, x1, y0, y1, colour, base, xs, ys);
        check({tag, " R7"}, "strobe gap after ack", gap_viol == 0, gap_viol, 0);
        check({tag, " R4"}, "strobe hold until ack", hold_viol == 0 && shape_viol == 0,
              hold_viol + shape_viol, 0);
    endtask

    task automatic t_forward();
        run_rect("fwd", 0, 4, 0, 3, 32'h11223344, 32'h0010_0000, 16'sd4, 16'sd1280, 0);
    endtask

    task automatic t_backward();
        run_rect("back", 10, 13, 5, 7, 32'ha5a5_5a5a, 32'h0020_0100, -16'sd4, -16'sd64, 2);
    endtask

    task automatic t_wrap_offset();
        run_rect("odd", 100, 105, 200, 202, 32'h0000_00ff, 32'hffff_fff8, 16'sd8, 16'sd40, 1);
    endtask

    task automatic t_empty();
        bit ok;
        ack_lat = 0;
        program_rect(7, 7, 0, 5, 32'h1, 32'h1000, 16'sd4, 16'sd64);
        log_n = 0;
        wr(3'd0, 32'd1);
        wait_done(ok);
        check("R8", "empty width done", ok, ok, 1);
        check("R8", "empty width no writes", log_n == 0, log_n, 0);
        program_rect(0, 9, 6, 2, 32'h1, 32'h1000, 16'sd4, 16'sd64);
        log_n = 0;
        wr(3'd0, 32'd1);
        wait_done(ok);
        check("R8", "empty height done", ok, ok, 1);
        check("R8", "empty height no writes", log_n == 0, log_n, 0);
    endtask

    task automatic t_restart_busy();
        bit ok;
        logic [31:0] s;
        ack_lat = 3;
        program_rect(0, 5, 0, 4, 32'hdead_beef, 32'h0003_0000, 16'sd4, 16'sd256);
        log_n = 0;
        wr(3'd0, 32'd1);
        repeat (12) @(negedge clk);
        wr(3'd0, 32'd1);
        repeat (7) @(negedge clk);
        wr(3'd0, 32'd1);
        wait_done(ok);
        check("R9", "done after restart attempts", ok, ok, 1);
        verify_log("R9 restart", 0, 5, 0, 4, 32'hdead_beef, 32'h0003_0000, 16'sd4, 16'sd256);
        repeat (20) @(negedge clk);
        rd(3'd0, s);
        check("R9", "done sticky while idle", s[1:0] == 2'b10, s, 2);
        check("R9", "no writes while idle", log_n == 20, log_n, 20);
        wr(3'd0, 32'd1);
        rd(3'd0, s);
        check("R3", "restart clears done", s[1:0] == 2'b01, s, 1);
        wait_done(ok);
        check("R3", "restart completes", ok && log_n == 40, log_n, 40);
    endtask

    task automatic t_reset_mid();
        logic [31:0] s;
        int n;
        ack_lat = 0;
        program_rect(0, 40, 0, 40, 32'h7, 32'h0, 16'sd4, 16'sd160);
        log_n = 0;
        wr(3'd0, 32'd1);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11", "bus quiet after mid reset", !bus_cyc && !bus_stb, bus_cyc, 0);
        rst = 1'b0;
        n = log_n;
        repeat (10) @(negedge clk);
        check("R11", "no writes after mid reset", log_n == n, log_n, n);
        rd(3'd0, s);
        check("R11", "status cleared after mid reset", s == 32'd0, s, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_forward();
        t_backward();
        t_wrap_offset();
        t_empty();
        t_restart_busy();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule